// File: doc/BRIEF.md
# Wired Interrupt Source Mode Controller

This block keeps the configuration and live state of a small array of wired interrupt sources, numbered from 1 up to `NUM_SRC`. Source number 0 is reserved and has no state. Each source stores a trigger mode, a pending flag, an enable flag and the input level seen on the previous clock. Every clock the block compares the incoming levels with the stored mode and raises pending flags. It then drives the bitwise AND of enable and pending to a downstream priority selector.

Software reaches the state through a command port. A command sets or clears pending or enable for one source, named by number, or for a group of sources given as a 32-bit bitmap word. A command can also rewrite a source's configuration. The port never applies back-pressure: `cmd_ready` is held high, and a command is taken in every cycle where `cmd_valid` is high. Its effect is visible from the following cycle. A combinational read port returns the pending, raw-input and enable bitmaps, or the configuration of one source. Sources handed to a child domain keep only a delegate flag, which freezes them.

Top module: `irq_source_ctrl`

## Requirements
- R1: Mode codes on 3 bits are 0 off, 1 detached, 4 rising edge, 5 falling edge, 6 level high and 7 level low. Codes 2 and 3 behave like off. A detached source ignores its input but still accepts software pending and enable commands.
- R2: The block samples `src_lvl` on every clock. A rising-edge source becomes pending when the current level is 1 and the sampled level is 0. A falling-edge source becomes pending on the opposite transition.
- R3: A level-high source becomes pending in any cycle where its input is 1. A level-low source becomes pending in any cycle where its input is 0.
- R4: Pending commands use these op codes: 1 set by number, 2 clear by number, 5 set by bitmap, 6 clear by bitmap. They are ignored for off sources and for delegated sources. With `MSG_MODE`=0 they are also ignored for level sources. With `MSG_MODE`=1 a set reaches a level source but a clear does not.
- R5: Enable commands use these op codes: 3 set by number, 4 clear by number, 7 set by bitmap, 8 clear by bitmap. They are ignored for off sources and for delegated sources.
- R6: Op 0 writes the configuration of source `cmd_sel`. Bit 10 of `cmd_data` is the delegate flag and bits 2:0 are the mode. When the delegate flag is set, the stored mode is 0. If the written configuration is all zero, or has the delegate flag set, that source's pending and enable flags are cleared. With `HAS_CHILD`=0 a write with the delegate flag set is stored as all zero.
- R7: A by-number command takes the source number from `cmd_data`. A bitmap command takes the word index from `cmd_sel`, and source s sits at word s/32, bit s%32. Commands aimed at source 0, or at numbers above `NUM_SRC`, change nothing. Bit 0 of bitmap word 0 always reads 0.
- R8: The read selector `rd_kind` works as follows: 0 reads the pending bitmap, 1 the raw sampled inputs, 2 the enable bitmap, 3 always zero, and 4 the configuration of source `rd_sel`. A configuration read returns the delegate flag at bit 10 and the mode at bits 2:0.
- R9: If a hardware pending condition and a software clear meet in the same cycle, the source ends that cycle pending.
- R10: After reset all flags, all configurations and all sampled inputs are zero. `req_vec` bit s is 1 exactly when source s is both pending and enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_lvl | input | NUM_SRC | Synchronised source levels, bit s is source s |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Always 1, command taken in the same cycle |
| cmd_op | input | 4 | Command op code |
| cmd_sel | input | SEL_W | Source number (config) or bitmap word index |
| cmd_data | input | 32 | Source number, bitmap, or configuration value |
| rd_kind | input | 3 | Read selector |
| rd_sel | input | SEL_W | Word index, or source number for a configuration read |
| rd_data | output | 32 | Read result (combinational) |
| req_vec | output | NUM_SRC | Enabled-and-pending vector, bit s is source s |

## Verification
Two events are the hardest to bring about: a new rising edge that arrives in the same cycle as a software clear, and a level source whose pending flag has to survive a clear. The first needs a source that is already pending, which is cleared at the exact clock where its input goes from 0 to 1. The second needs a level source that has gone pending and then sees its input drop. Directed steps set up both situations, and random traffic follows them. In that traffic, random levels, random mode rewrites and bitmap commands hit all sources at once. Each cycle is checked against a cycle-accurate reference model held in the bench.

// File: rtl/irq_src_pkg.sv
`timescale 1ns/1ps
package irq_src_pkg;

  localparam logic [2:0] MD_OFF    = 3'd0;
  localparam logic [2:0] MD_DETACH = 3'd1;
  localparam logic [2:0] MD_RISE   = 3'd4;
  localparam logic [2:0] MD_FALL   = 3'd5;
  localparam logic [2:0] MD_HIGH   = 3'd6;
  localparam logic [2:0] MD_LOW    = 3'd7;

  localparam logic [3:0] OP_CFG       = 4'd0;
  localparam logic [3:0] OP_SETP_NUM  = 4'd1;
  localparam logic [3:0] OP_CLRP_NUM  = 4'd2;
  localparam logic [3:0] OP_SETE_NUM  = 4'd3;
  localparam logic [3:0] OP_CLRE_NUM  = 4'd4;
  localparam logic [3:0] OP_SETP_MAP  = 4'd5;
  localparam logic [3:0] OP_CLRP_MAP  = 4'd6;
  localparam logic [3:0] OP_SETE_MAP  = 4'd7;
  localparam logic [3:0] OP_CLRE_MAP  = 4'd8;

  localparam logic [2:0] RK_PEND  = 3'd0;
  localparam logic [2:0] RK_INPUT = 3'd1;
  localparam logic [2:0] RK_ENA   = 3'd2;
  localparam logic [2:0] RK_ZERO  = 3'd3;
  localparam logic [2:0] RK_CFG   = 3'd4;

  localparam int DELEG_BIT = 10;

  typedef struct packed {
    logic       del;
    logic [2:0] mode;
  } src_cfg_t;

endpackage

// File: rtl/irq_cmd_decode.sv
`timescale 1ns/1ps
module irq_cmd_decode
  import irq_src_pkg::*;
#(
  parameter int NUM_SRC   = 31,
  parameter int SEL_W     = 10,
  parameter bit HAS_CHILD = 1'b1
) (
  input  logic               cmd_valid,
  input  logic [3:0]         cmd_op,
  input  logic [SEL_W-1:0]   cmd_sel,
  input  logic [31:0]        cmd_data,
  output logic [NUM_SRC:1]   set_ip,
  output logic [NUM_SRC:1]   clr_ip,
  output logic [NUM_SRC:1]   set_ie,
  output logic [NUM_SRC:1]   clr_ie,
  output logic [NUM_SRC:1]   cfg_we,
  output src_cfg_t           cfg_new
);

  // configuration value to store; delegate drops the mode
  always_comb begin
    cfg_new = '0;
    if (cmd_data[DELEG_BIT]) begin
      cfg_new.del = HAS_CHILD;
    end else begin
      cfg_new.mode = cmd_data[2:0];
    end
  end

  for (genvar s = 1; s <= NUM_SRC; s++) begin : g_src
    localparam int WORD = s / 32;
    localparam int BIT  = s % 32;
    logic hit_num;
    logic hit_map;
    assign hit_num = (cmd_data == 32'(s));
    assign hit_map = (cmd_sel == SEL_W'(WORD)) && cmd_data[BIT];

    assign set_ip[s] = cmd_valid && ((cmd_op == OP_SETP_NUM && hit_num) ||
                                     (cmd_op == OP_SETP_MAP && hit_map));
    assign clr_ip[s] = cmd_valid && ((cmd_op == OP_CLRP_NUM && hit_num) ||
                                     (cmd_op == OP_CLRP_MAP && hit_map));
    assign set_ie[s] = cmd_valid && ((cmd_op == OP_SETE_NUM && hit_num) ||
                                     (cmd_op == OP_SETE_MAP && hit_map));
    assign clr_ie[s] = cmd_valid && ((cmd_op == OP_CLRE_NUM && hit_num) ||
                                     (cmd_op == OP_CLRE_MAP && hit_map));
    assign cfg_we[s] = cmd_valid && (cmd_op == OP_CFG) &&
                       (cmd_sel == SEL_W'(s));
  end

endmodule

// File: rtl/irq_src_slot.sv
`timescale 1ns/1ps
module irq_src_slot
  import irq_src_pkg::*;
#(
  parameter bit MSG_MODE = 1'b0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     lvl,
  input  logic     set_ip,
  input  logic     clr_ip,
  input  logic     set_ie,
  input  logic     clr_ie,
  input  logic     cfg_we,
  input  src_cfg_t cfg_new,
  output logic     pend,
  output logic     en,
  output logic     samp,
  output src_cfg_t cfg
);

  logic hw_hit;
  logic live;
  logic is_level;
  logic sw_set_ok;
  logic sw_clr_ok;
  logic pend_d;
  logic en_d;

  // trigger condition from the stored mode
  always_comb begin
    unique case (cfg.mode)
      MD_RISE: hw_hit = lvl & ~samp;
      MD_FALL: hw_hit = ~lvl & samp;
      MD_HIGH: hw_hit = lvl;
      MD_LOW:  hw_hit = ~lvl;
      default: hw_hit = 1'b0;
    endcase
    if (cfg.del) hw_hit = 1'b0;
  end

  assign live      = !cfg.del && (cfg.mode == MD_DETACH || cfg.mode[2]);
  assign is_level  = (cfg.mode == MD_HIGH) || (cfg.mode == MD_LOW);
  assign sw_set_ok = live && (!is_level || MSG_MODE);
  assign sw_clr_ok = live && !is_level;

  // hardware set wins over a same-cycle software clear
  assign pend_d = hw_hit | (pend & ~(clr_ip & sw_clr_ok)) | (set_ip & sw_set_ok);
  assign en_d   = (en & ~(clr_ie & live)) | (set_ie & live);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
      en   <= 1'b0;
      samp <= 1'b0;
      cfg  <= '0;
    end else begin
      samp <= lvl;
      if (cfg_we) begin
        cfg <= cfg_new;
        if (cfg_new == '0 || cfg_new.del) begin
          pend <= 1'b0;
          en   <= 1'b0;
        end else begin
          pend <= pend_d;
          en   <= en_d;
        end
      end else begin
        pend <= pend_d;
        en   <= en_d;
      end
    end
  end

endmodule

// File: rtl/irq_read_mux.sv
`timescale 1ns/1ps
module irq_read_mux
  import irq_src_pkg::*;
#(
  parameter int NUM_SRC = 31,
  parameter int SEL_W   = 10
) (
  input  logic [NUM_SRC:1]            pend_v,
  input  logic [NUM_SRC:1]            en_v,
  input  logic [NUM_SRC:1]            in_v,
  input  src_cfg_t [NUM_SRC:1]        cfg_v,
  input  logic [2:0]                  rd_kind,
  input  logic [SEL_W-1:0]            rd_sel,
  output logic [31:0]                 rd_data
);

  localparam int NWORDS = (NUM_SRC + 32) / 32;
  localparam int PADW   = NWORDS * 32;

  logic [PADW-1:0] pend_pad;
  logic [PADW-1:0] en_pad;
  logic [PADW-1:0] in_pad;

  always_comb begin
    pend_pad = '0;
    en_pad   = '0;
    in_pad   = '0;
    pend_pad[NUM_SRC:1] = pend_v;
    en_pad[NUM_SRC:1]   = en_v;
    in_pad[NUM_SRC:1]   = in_v;
  end

  always_comb begin
    rd_data = '0;
    if (rd_kind == RK_CFG) begin
      for (int s = 1; s <= NUM_SRC; s++) begin
        if (rd_sel == SEL_W'(s)) begin
          rd_data[DELEG_BIT] = cfg_v[s].del;
          rd_data[2:0]       = cfg_v[s].mode;
        end
      end
    end else begin
      for (int w = 0; w < NWORDS; w++) begin
        if (rd_sel == SEL_W'(w)) begin
          unique case (rd_kind)
            RK_PEND:  rd_data = pend_pad[w*32 +: 32];
            RK_INPUT: rd_data = in_pad[w*32 +: 32];
            RK_ENA:   rd_data = en_pad[w*32 +: 32];
            default:  rd_data = '0;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/irq_source_ctrl.sv
`timescale 1ns/1ps
module irq_source_ctrl
  import irq_src_pkg::*;
#(
  parameter int NUM_SRC   = 31,
  parameter int SEL_W     = 10,
  parameter bit HAS_CHILD = 1'b1,
  parameter bit MSG_MODE  = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC:1]   src_lvl,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [3:0]         cmd_op,
  input  logic [SEL_W-1:0]   cmd_sel,
  input  logic [31:0]        cmd_data,
  input  logic [2:0]         rd_kind,
  input  logic [SEL_W-1:0]   rd_sel,
  output logic [31:0]        rd_data,
  output logic [NUM_SRC:1]   req_vec
);

  logic [NUM_SRC:1]     set_ip;
  logic [NUM_SRC:1]     clr_ip;
  logic [NUM_SRC:1]     set_ie;
  logic [NUM_SRC:1]     clr_ie;
  logic [NUM_SRC:1]     cfg_we;
  src_cfg_t             cfg_new;
  logic [NUM_SRC:1]     pend_v;
  logic [NUM_SRC:1]     en_v;
  logic [NUM_SRC:1]     in_v;
  src_cfg_t [NUM_SRC:1] cfg_v;

  assign cmd_ready = 1'b1;

  irq_cmd_decode #(
    .NUM_SRC(NUM_SRC), .SEL_W(SEL_W), .HAS_CHILD(HAS_CHILD)
  ) u_dec (
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_sel(cmd_sel),
    .cmd_data(cmd_data), .set_ip(set_ip), .clr_ip(clr_ip),
    .set_ie(set_ie), .clr_ie(clr_ie), .cfg_we(cfg_we), .cfg_new(cfg_new)
  );

  for (genvar s = 1; s <= NUM_SRC; s++) begin : g_slot
    irq_src_slot #(.MSG_MODE(MSG_MODE)) u_slot (
      .clk(clk), .rst_n(rst_n), .lvl(src_lvl[s]),
      .set_ip(set_ip[s]), .clr_ip(clr_ip[s]),
      .set_ie(set_ie[s]), .clr_ie(clr_ie[s]),
      .cfg_we(cfg_we[s]), .cfg_new(cfg_new),
      .pend(pend_v[s]), .en(en_v[s]), .samp(in_v[s]), .cfg(cfg_v[s])
    );
  end

  irq_read_mux #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_rd (
    .pend_v(pend_v), .en_v(en_v), .in_v(in_v), .cfg_v(cfg_v),
    .rd_kind(rd_kind), .rd_sel(rd_sel), .rd_data(rd_data)
  );

  assign req_vec = pend_v & en_v;

endmodule

// File: rtl/irq_src_chk.sv
`timescale 1ns/1ps
module irq_src_chk
  import irq_src_pkg::*;
#(
  parameter int NUM_SRC = 31,
  parameter int SEL_W   = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC:1]     src_lvl,
  input  logic [NUM_SRC:1]     pend_v,
  input  logic [NUM_SRC:1]     en_v,
  input  src_cfg_t [NUM_SRC:1] cfg_v,
  input  logic [NUM_SRC:1]     cfg_we,
  input  src_cfg_t             cfg_new,
  input  logic [2:0]           rd_kind,
  input  logic [SEL_W-1:0]     rd_sel,
  input  logic [31:0]          rd_data
);

  // R7
  bit0_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_kind != RK_CFG && rd_sel == '0) |-> !rd_data[0]);

  for (genvar s = 1; s <= NUM_SRC; s++) begin : g_chk
    // R3
    level_high_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_v[s].del && cfg_v[s].mode == MD_HIGH && src_lvl[s] && !cfg_we[s])
      |=> pend_v[s]);

    // R4
    level_clear_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_v[s].mode[2:1] == 2'b11 && pend_v[s] && !cfg_we[s]) |=> pend_v[s]);

    // R5
    frozen_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((cfg_v[s].del || !(cfg_v[s].mode == MD_DETACH || cfg_v[s].mode[2]))
       && !cfg_we[s]) |=> $stable(en_v[s]));

    // R6
    cfg_clears_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we[s] && (cfg_new == '0 || cfg_new.del)) |=> (!pend_v[s] && !en_v[s]));
  end

endmodule

bind irq_source_ctrl irq_src_chk #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .pend_v(pend_v),
  .en_v(en_v), .cfg_v(cfg_v), .cfg_we(cfg_we), .cfg_new(cfg_new),
  .rd_kind(rd_kind), .rd_sel(rd_sel), .rd_data(rd_data)
);

// File: tb/test_irq_source_ctrl.sv
`timescale 1ns/1ps
module test_irq_source_ctrl;

  localparam int N  = 31;
  localparam int SW = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N:1]    src_lvl;
  logic          cmd_valid;
  logic          cmd_ready;
  logic [3:0]    cmd_op;
  logic [SW-1:0] cmd_sel;
  logic [31:0]   cmd_data;
  logic [2:0]    rd_kind;
  logic [SW-1:0] rd_sel;
  logic [31:0]   rd_data;
  logic [N:1]    req_vec;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  bit       m_pend [1:N];
  bit       m_en   [1:N];
  bit       m_samp [1:N];
  bit       m_del  [1:N];
  bit [2:0] m_mode [1:N];
  int       cfg_peek = 1;

  irq_source_ctrl #(.NUM_SRC(N), .SEL_W(SW), .HAS_CHILD(1'b1), .MSG_MODE(1'b0))
  i_irq_source_ctrl (
    .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_sel(cmd_sel),
    .cmd_data(cmd_data), .rd_kind(rd_kind), .rd_sel(rd_sel),
    .rd_data(rd_data), .req_vec(req_vec)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] map_of(input int kind);
    logic [31:0] v = '0;
    for (int s = 1; s <= N; s++) begin
      case (kind)
        0: v[s] = m_pend[s];
        1: v[s] = m_samp[s];
        2: v[s] = m_en[s];
        default: v[s] = m_pend[s] & m_en[s];
      endcase
    end
    return v;
  endfunction

  // compare every visible output with the reference model
  task automatic check_all(input string tag);
    logic [31:0] exp_cfg;
    logic [31:0] rv;
    rd_sel = '0;
    rd_kind = 3'd0; #0.2;
    chk(tag, "pending map", rd_data, map_of(0));
    rd_kind = 3'd1; #0.2;
    chk(tag, "input map", rd_data, map_of(1));
    rd_kind = 3'd2; #0.2;
    chk(tag, "enable map", rd_data, map_of(2));
    rd_kind = 3'd3; #0.2;
    chk(tag, "clear-enable read", rd_data, 32'd0);
    rd_kind = 3'd4; rd_sel = SW'(cfg_peek); #0.2;
    exp_cfg = '0;
    exp_cfg[10]  = m_del[cfg_peek];
    exp_cfg[2:0] = m_mode[cfg_peek];
    chk(tag, "config read", rd_data, exp_cfg);
    cfg_peek = (cfg_peek % N) + 1;
    rv = '0;
    rv[N:1] = req_vec;
    chk(tag, "req_vec", rv, map_of(3));
    chk(tag, "cmd_ready", {31'd0, cmd_ready}, 32'd1);
  endtask

  // reference model of one clock, derived from the requirements
  task automatic model_step(input logic [N:1] lv, input logic vld,
                            input logic [3:0] op, input logic [SW-1:0] sel,
                            input logic [31:0] dat);
    for (int s = 1; s <= N; s++) begin
      bit hit_n, hit_m, sip, cip, sie, cie, cw, act, lvm, hw, np, ne;
      hit_n = (dat == 32'(s));
      hit_m = (sel == SW'(s / 32)) && dat[s % 32];
      sip = vld && ((op == 4'd1 && hit_n) || (op == 4'd5 && hit_m));
      cip = vld && ((op == 4'd2 && hit_n) || (op == 4'd6 && hit_m));
      sie = vld && ((op == 4'd3 && hit_n) || (op == 4'd7 && hit_m));
      cie = vld && ((op == 4'd4 && hit_n) || (op == 4'd8 && hit_m));
      cw  = vld && op == 4'd0 && sel == SW'(s);
      act = !m_del[s] && (m_mode[s] == 3'd1 || m_mode[s] >= 3'd4);
      lvm = m_mode[s] >= 3'd6;
      hw  = !m_del[s] && ((m_mode[s] == 3'd4 && lv[s] && !m_samp[s]) ||
                          (m_mode[s] == 3'd5 && !lv[s] && m_samp[s]) ||
                          (m_mode[s] == 3'd6 && lv[s]) ||
                          (m_mode[s] == 3'd7 && !lv[s]));
      np = hw || (m_pend[s] && !(cip && act && !lvm)) || (sip && act && !lvm);
      ne = (m_en[s] && !(cie && act)) || (sie && act);
      if (cw) begin
        m_del[s]  = dat[10];
        m_mode[s] = dat[10] ? 3'd0 : dat[2:0];
        if (m_del[s] || m_mode[s] == 3'd0) begin
          np = 0;
          ne = 0;
        end
      end
      m_pend[s] = np;
      m_en[s]   = ne;
      m_samp[s] = lv[s];
    end
  endtask

  task automatic step(input logic [N:1] lv, input logic vld, input logic [3:0] op,
                      input logic [SW-1:0] sel, input logic [31:0] dat,
                      input string tag);
    src_lvl = lv; cmd_valid = vld; cmd_op = op; cmd_sel = sel; cmd_data = dat;
    model_step(lv, vld, op, sel, dat);
    @(posedge clk);
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    logic [N:1] lv;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; src_lvl = '0; cmd_valid = 0; cmd_op = '0; cmd_sel = '0;
    cmd_data = '0; rd_kind = '0; rd_sel = '0;
    for (int s = 1; s <= N; s++) begin
      m_pend[s] = 0; m_en[s] = 0; m_samp[s] = 0; m_del[s] = 0; m_mode[s] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check_all("R10 reset");

    lv = '0;
    // R6 configure source 3 as level high
    step(lv, 1, 4'd0, 10'd3, 32'd6, "R6");
    // R3 level high sets pending
    lv[3] = 1'b1;
    step(lv, 0, 4'd0, 10'd0, 32'd0, "R3");
    // R5 enable source 3, R10 request appears
    step(lv, 1, 4'd3, 10'd0, 32'd3, "R5");
    // R4 clear on a level source in direct mode is ignored
    lv[3] = 1'b0;
    step(lv, 1, 4'd2, 10'd0, 32'd3, "R4");
    // R2 rising edge on source 5
    step(lv, 1, 4'd0, 10'd5, 32'd4, "R2");
    lv[5] = 1'b1;
    step(lv, 0, 4'd0, 10'd0, 32'd0, "R2");
    step(lv, 1, 4'd2, 10'd0, 32'd5, "R4");
    lv[5] = 1'b0;
    step(lv, 0, 4'd0, 10'd0, 32'd0, "R2");
    step(lv, 1, 4'd1, 10'd0, 32'd5, "R4");
    // R9 new edge and software clear in the same cycle
    lv[5] = 1'b1;
    step(lv, 1, 4'd2, 10'd0, 32'd5, "R9");
    // R2 falling edge on source 7
    lv[7] = 1'b1;
    step(lv, 1, 4'd0, 10'd7, 32'd5, "R2");
    lv[7] = 1'b0;
    step(lv, 0, 4'd0, 10'd0, 32'd0, "R2");
    // R4 and R5 commands on an off source
    step(lv, 1, 4'd1, 10'd0, 32'd9, "R4");
    step(lv, 1, 4'd3, 10'd0, 32'd9, "R5");
    // R1 code 2 acts as off, detached ignores input
    lv[9] = 1'b1; lv[10] = 1'b1;
    step(lv, 1, 4'd0, 10'd9, 32'd2, "R1");
    step(lv, 1, 4'd0, 10'd10, 32'd1, "R1");
    step(lv, 1, 4'd1, 10'd0, 32'd10, "R1");
    // R6 delegation clears, R5 enable then refused
    step(lv, 1, 4'd0, 10'd3, 32'h0000_0406, "R6");
    step(lv, 1, 4'd3, 10'd0, 32'd3, "R5");
    // R7 source 0, out of range, bitmaps
    step(lv, 1, 4'd1, 10'd0, 32'd0, "R7");
    step(lv, 1, 4'd1, 10'd0, 32'd32, "R7");
    step(lv, 1, 4'd7, 10'd1, 32'hFFFF_FFFF, "R7");
    step(lv, 1, 4'd7, 10'd0, 32'hFFFF_FFFF, "R7");
    step(lv, 1, 4'd5, 10'd0, 32'hFFFF_FFFF, "R7");
    step(lv, 1, 4'd6, 10'd0, 32'hFFFF_FFFF, "R8");

    // random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      logic [3:0]    op;
      logic [SW-1:0] sel;
      logic [31:0]   dat;
      op  = 4'($urandom_range(0, 9));
      sel = SW'($urandom_range(0, 2));
      dat = $urandom;
      if (op == 4'd0) begin
        sel = SW'($urandom_range(0, 33));
        dat = {21'd0, ($urandom_range(0, 9) == 0), 7'd0, 3'($urandom_range(0, 7))};
      end else if (op <= 4'd4) begin
        dat = 32'($urandom_range(0, 34));
      end
      lv = N'($urandom);
      step(lv, ($urandom_range(0, 4) != 0), op, sel, dat, "R10 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule